// File: doc/BRIEF.md
# If-Then Block Predication Unit

This unit sits beside an in-order pipeline and decides, one instruction at a time, whether the instruction that follows an if-then command is executed or squashed. A command carries a base condition code, a block length of one to four slots, and a then/else pattern. The unit then steps through the block, one slot per advance strobe. For every slot it tests either the base condition or its logical inverse against the live N, Z, C and V flags. Every slot after the block's last slot runs unconditionally again.

The condition evaluator covers all sixteen 4-bit codes. Paired codes differ only in their least significant bit and are logical inverses of each other, so an "else" slot is formed by flipping that bit. Flags are read in the cycle in which a slot is presented. A flag update made by an earlier slot of the block therefore governs the slots that come after it. While no block is active, every instruction executes whatever the flags hold.

Top module: `it_pred_unit`

## Requirements
- R1: After synchronous reset no block is active, `slot_exec` is 1 and `slot_pos` is 0.
- R2: A `cmd_valid` pulse seen while no block is active starts a block in the next cycle. The block starts at slot 0 and holds `cmd_len`+1 slots (`cmd_len` = 0..3 gives 1..4 slots).
- R3: Flag bits are `flags[3]`=N, `flags[2]`=Z, `flags[1]`=C, `flags[0]`=V. The simple codes test one flag each:
  - 0 passes on Z set and 1 passes on Z clear.
  - 2 passes on C set and 3 passes on C clear.
  - 4 passes on N set and 5 passes on N clear.
  - 6 passes on V set and 7 passes on V clear.
- R4: The compound codes:
  - 8 passes when C is set and Z is clear; 9 passes when C is clear or Z is set.
  - 10 passes when N equals V; 11 passes when N differs from V.
  - 12 passes when Z is clear and N equals V; 13 passes when Z is set or N differs from V.
- R5: Codes 14 and 15 always pass, including in else slots.
- R6: Slot 0 always tests the base code. Slot k (k = 1..3) tests the base code when `cmd_pat[k-1]` is 0, and the code with its least significant bit flipped when `cmd_pat[k-1]` is 1.
- R7: Within an active slot, `slot_exec` follows the present `flags` combinationally. A flag change between slots governs the later slots.
- R8: Each `adv` strobe during a block moves to the next slot. An `adv` on the last slot ends the block in the next cycle.
- R9: A `cmd_valid` seen while a block is active is ignored. The running block keeps its slot, conditions and length.
- R10: With no block active, `slot_exec` is 1 for every flag value and `adv` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Strobe carrying an if-then command |
| cmd_cond | input | 4 | Base condition code of the command |
| cmd_len | input | 2 | Number of slots minus one |
| cmd_pat | input | 3 | Bit k-1 set makes slot k an else slot |
| flags | input | 4 | Live N, Z, C, V flags (bits 3..0) |
| adv | input | 1 | One instruction consumed; step to next slot |
| blk_active | output | 1 | A block is in progress |
| slot_exec | output | 1 | 1 = execute present instruction, 0 = squash |
| slot_pos | output | 2 | Index of the present slot in the block |

## Verification
The bench builds the unit with its default of four slots and 4-bit condition codes. At that size every code can be swept against all sixteen flag combinations. Every code is also run through all thirty-two length and then/else pattern combinations, with a different flag value per slot. This brings every inverted compound code, including the always-pass pair, within reach. Directed sequences cover a stray command in mid-block and strobes issued while no block is active.

// File: rtl/it_pred_pkg.sv
package it_pred_pkg;

    typedef enum logic [3:0] {
        C_EQ = 4'd0,  C_NE = 4'd1,  C_CS = 4'd2,  C_CC = 4'd3,
        C_MI = 4'd4,  C_PL = 4'd5,  C_VS = 4'd6,  C_VC = 4'd7,
        C_HI = 4'd8,  C_LS = 4'd9,  C_GE = 4'd10, C_LT = 4'd11,
        C_GT = 4'd12, C_LE = 4'd13, C_AL = 4'd14, C_NV = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_s;

    // Paired codes are inverses; flipping bit 0 turns "then" into "else".
    function automatic cond_e cond_flip(cond_e c, logic inv);
        return cond_e'({c[3:1], c[0] ^ inv});
    endfunction

endpackage

// File: rtl/it_cond_eval.sv
module it_cond_eval
    import it_pred_pkg::*;
(
    input  cond_e cond,
    input  nzcv_s fl,
    output logic  pass
);
    logic base;
    logic n_eq_v;

    always_comb begin
        n_eq_v = (fl.n == fl.v);
        base   = 1'b1;
        case (cond[3:1])
            3'd0: base = fl.z;
            3'd1: base = fl.c;
            3'd2: base = fl.n;
            3'd3: base = fl.v;
            3'd4: base = fl.c & ~fl.z;
            3'd5: base = n_eq_v;
            3'd6: base = ~fl.z & n_eq_v;
            3'd7: base = 1'b1;
            default: base = 1'b1;
        endcase
        // the top pair has no inverse: both codes pass
        pass = (cond[3:1] == 3'd7) ? 1'b1 : (base ^ cond[0]);
    end
endmodule

// File: rtl/it_slot_seq.sv
module it_slot_seq
    import it_pred_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int LEN_W = (SLOTS > 2) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  cond_e            cmd_cond,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [SLOTS-2:0] cmd_pat,
    input  logic             adv,
    output logic             active,
    output logic [LEN_W-1:0] pos,
    output cond_e            cur_cond
);
    typedef struct packed {
        logic             act;
        cond_e            base;
        logic [LEN_W-1:0] pos;
        logic [LEN_W-1:0] last;
        logic [SLOTS-1:0] inv;
    } seq_st_s;

    seq_st_s          st_q, st_d;
    logic [SLOTS-1:0] new_inv;
    logic             accept;

    assign new_inv[0] = 1'b0;
    for (genvar g = 1; g < SLOTS; g++) begin : g_inv
        assign new_inv[g] = cmd_pat[g-1];
    end

    assign accept = cmd_valid & ~st_q.act;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.act  = 1'b1;
            st_d.base = cmd_cond;
            st_d.pos  = '0;
            st_d.last = cmd_len;
            st_d.inv  = new_inv;
        end else if (st_q.act && adv) begin
            if (st_q.pos == st_q.last) begin
                st_d.act = 1'b0;
                st_d.pos = '0;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign active   = st_q.act;
    assign pos      = st_q.pos;
    assign cur_cond = cond_flip(st_q.base, st_q.inv[st_q.pos]);
endmodule

// File: rtl/it_pred_unit.sv
module it_pred_unit
    import it_pred_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int LEN_W = (SLOTS > 2) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_cond,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [SLOTS-2:0] cmd_pat,
    input  logic [3:0]       flags,
    input  logic             adv,
    output logic             blk_active,
    output logic             slot_exec,
    output logic [LEN_W-1:0] slot_pos
);
    cond_e cur_cond;
    logic  pass;
    nzcv_s fl;

    assign fl = nzcv_s'(flags);

    it_slot_seq #(.SLOTS(SLOTS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .cmd_valid(cmd_valid),
        .cmd_cond (cond_e'(cmd_cond)),
        .cmd_len  (cmd_len),
        .cmd_pat  (cmd_pat),
        .adv      (adv),
        .active   (blk_active),
        .pos      (slot_pos),
        .cur_cond (cur_cond)
    );

    it_cond_eval u_eval (
        .cond(cur_cond),
        .fl  (fl),
        .pass(pass)
    );

    assign slot_exec = blk_active ? pass : 1'b1;
endmodule

// File: rtl/it_pred_chk.sv
module it_pred_chk #(
    parameter int LEN_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [3:0]       cmd_cond,
    input logic [LEN_W-1:0] cmd_len,
    input logic             adv,
    input logic             blk_active,
    input logic             slot_exec,
    input logic [LEN_W-1:0] slot_pos
);
    logic [LEN_W-1:0] len_q;
    logic [3:0]       cond_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= '0;
            cond_q <= '0;
        end else if (cmd_valid && !blk_active) begin
            len_q  <= cmd_len;
            cond_q <= cmd_cond;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!blk_active && slot_pos == '0));

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !blk_active) |=> (blk_active && slot_pos == '0));

    p_al_first_r5: assert property (@(posedge clk) disable iff (rst)
        (blk_active && slot_pos == '0 && cond_q[3:1] == 3'b111) |-> slot_exec);

    p_step_r8: assert property (@(posedge clk) disable iff (rst)
        (blk_active && adv && slot_pos != len_q) |=>
            (blk_active && slot_pos == $past(slot_pos) + 1'b1));

    p_end_r8: assert property (@(posedge clk) disable iff (rst)
        (blk_active && adv && slot_pos == len_q) |=> !blk_active);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (blk_active && !adv) |=> (blk_active && $stable(slot_pos)));

    p_idle_exec_r10: assert property (@(posedge clk) disable iff (rst)
        !blk_active |-> slot_exec);

    p_idle_stay_r10: assert property (@(posedge clk) disable iff (rst)
        (!blk_active && !cmd_valid) |=> !blk_active);
endmodule

bind it_pred_unit it_pred_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_cond  (cmd_cond),
    .cmd_len   (cmd_len),
    .adv       (adv),
    .blk_active(blk_active),
    .slot_exec (slot_exec),
    .slot_pos  (slot_pos)
);

// File: tb/sim_it_pred_unit.sv
`timescale 1ns/1ps
module sim_it_pred_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_cond = '0;
    logic [1:0] cmd_len = '0;
    logic [2:0] cmd_pat = '0;
    logic [3:0] flags = '0;
    logic       adv = 1'b0;
    logic       blk_active, slot_exec;
    logic [1:0] slot_pos;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    it_pred_unit u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_cond(cmd_cond),
        .cmd_len(cmd_len), .cmd_pat(cmd_pat), .flags(flags), .adv(adv),
        .blk_active(blk_active), .slot_exec(slot_exec), .slot_pos(slot_pos)
    );

    // expected pass per code; flags are {N,Z,C,V}
    function automatic bit exp_pass(input int code, input logic [3:0] f);
        bit n = f[3], z = f[2], c = f[1], v = f[0];
        case (code)
            0: return z;            1: return !z;
            2: return c;            3: return !c;
            4: return n;            5: return !n;
            6: return v;            7: return !v;
            8: return c && !z;      9: return !c || z;
            10: return n == v;      11: return n != v;
            12: return !z && (n == v);
            13: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic load(input int c, input int l, input int p);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_cond = 4'(c); cmd_len = 2'(l); cmd_pat = 3'(p);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic step();
        adv = 1'b1;
        @(negedge clk);
        adv = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(!blk_active, "R1 active", blk_active, 0);
        chk(slot_exec, "R1 exec", slot_exec, 1);
        chk(slot_pos == 0, "R1 pos", slot_pos, 0);

        // R10: idle, every flag value executes; adv ignored
        for (int f = 0; f < 16; f++) begin
            flags = 4'(f);
            #1 chk(slot_exec, "R10 idle exec", slot_exec, 1);
        end
        for (int k = 0; k < 3; k++) step();
        #1 chk(!blk_active, "R10 adv while idle", blk_active, 0);

        // R3 R4 R5 R7: single-slot sweep, flags varied live within slot 0
        for (int c = 0; c < 16; c++) begin
            load(c, 0, 0);
            chk(blk_active && slot_pos == 0, "R2 start", blk_active, 1);
            for (int f = 0; f < 16; f++) begin
                flags = 4'(f);
                #1;
                if (c < 8)       chk(slot_exec == exp_pass(c, 4'(f)), "R3 code", slot_exec, exp_pass(c, 4'(f)));
                else if (c < 14) chk(slot_exec == exp_pass(c, 4'(f)), "R4 code", slot_exec, exp_pass(c, 4'(f)));
                else             chk(slot_exec == 1'b1, "R5 always", slot_exec, 1);
                chk(slot_pos == 0, "R7 live flags keep slot", slot_pos, 0);
            end
            step();
            #1 chk(!blk_active, "R8 single slot ends", blk_active, 0);
        end

        // R6 R8 R2: every code, length and pattern
        for (int c = 0; c < 16; c++) begin
            for (int l = 0; l < 4; l++) begin
                for (int p = 0; p < 8; p++) begin
                    load(c, l, p);
                    for (int s = 0; s <= l; s++) begin
                        int eff;
                        logic [3:0] f;
                        f = 4'((c * 5 + s * 7 + p * 3 + l) & 15);
                        flags = f;
                        eff = (s == 0) ? c : (((p >> (s - 1)) & 1) != 0 ? (c ^ 1) : c);
                        #1;
                        chk(blk_active, "R8 active in block", blk_active, 1);
                        chk(slot_pos == 2'(s), "R8 slot index", slot_pos, s);
                        chk(slot_exec == exp_pass(eff, f), "R6 then/else", slot_exec, exp_pass(eff, f));
                        step();
                    end
                    #1 chk(!blk_active, "R8 block ends", blk_active, 0);
                end
            end
        end

        // R9: stray command in mid-block is ignored
        load(0, 3, 0);
        step();
        flags = 4'b0000;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_cond = 4'd14; cmd_len = 2'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        chk(slot_pos == 1, "R9 pos kept", slot_pos, 1);
        chk(slot_exec == 1'b0, "R9 cond kept", slot_exec, 0);
        step(); step();
        #1 chk(blk_active && slot_pos == 3, "R9 length kept", slot_pos, 3);
        step();
        #1 chk(!blk_active, "R9 block ends on own length", blk_active, 0);

        // R7: flag change between slots governs later slot
        load(1, 1, 0);
        flags = 4'b0000;
        #1 chk(slot_exec, "R7 slot0 NE z=0", slot_exec, 1);
        step();
        flags = 4'b0100;
        #1 chk(!slot_exec, "R7 slot1 NE z=1", slot_exec, 0);
        step();

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule